// File: doc/BRIEF.md
# Interrupt controller register and enable core

This block is the register-state core of a per-processor interrupt controller. It holds three bit vectors, each with one bit per interrupt vector: pending requests, vectors in service and trigger mode. It also holds a 64-bit command register, a logical destination, a destination format and a task priority. Beside these sit a set of local vector entries, each with a mask bit, the timer initial count, the timer current count and the timer divide setting, a spurious-vector register and two identifiers. A single-cycle write strobe and a combinational read port give access to every register. Prioritisation, timer counting and bus arbitration are handled elsewhere.

The block applies fixed values on reset and leaves reset with software enable off. Bit 8 of the spurious-vector register is the software enable. While the block is disabled, every vector-entry mask is held at 1 and writes cannot clear one, but pending and in-service bits are kept. An IPI that is in flight delays the disable until it has finished. The block also tells its neighbours which incoming control messages and pins to act on. The decision depends on whether this processor is the bootstrap one or an application one, and on the enable state.

Top module: `intc_regs`

## Requirements
- R1: After reset, request, in-service, trigger-mode, command (both words), logical destination, task priority, timer initial count, timer current count and divide setting all read 0.
- R2: After reset, the destination format register (word 0x05) reads 0xFFFFFFFF.
- R3: After reset, each vector entry (word 0x10+i) reads 0x00010000: bit 16 is the mask and is 1, and the other bits are 0.
- R4: After reset, the spurious-vector register (word 0x06) reads 0x0FF and `sw_enabled` is 0.
- R5: After reset, the identifier (word 0x00) and the arbitration identifier (word 0x02) both read `id_strap`. The version word (0x01) always reads the parameter VERSION.
- R6: While `sw_enabled` is 0, every vector-entry mask reads 1. A write to an entry still updates bits 15:0, but cannot clear bit 16.
- R7: A change of the enable bit leaves the request bits (words 0x20+w) and in-service bits (words 0x28+w) unchanged.
- R8: A write that clears bit 8 of word 0x06 drops `sw_enabled` at that clock edge if `ipi_busy` is 0. If `ipi_busy` is 1, `sw_enabled` stays 1 and the masks stay as they are until the first edge with `ipi_busy` at 0.
- R9: `msg_accept` is `msg_valid` qualified by `msg_type`. INIT (0), NMI (1) and SMI (2) are always accepted. Startup (3) is accepted only when `bsp_role` is 0. Fixed (4) is accepted only when `sw_enabled` is 1. Any other code is never accepted.
- R10: `init_accept` follows `init_pin` in both roles. `stopclk_accept` follows `stopclk_pin` only when `bsp_role` is 1.
- R11: Setting the enable bit again leaves every mask at 1 until software writes a 0 to that entry's bit 16.
- R12: A write takes effect at the clock edge where `wr_en` is high. Reads are combinational. Writing the timer initial count (0x09) also loads the timer current count (0x0A, read-only). The divide setting (0x0B) keeps bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_strap | input | 8 | Identifier loaded at reset |
| bsp_role | input | 1 | 1 = bootstrap processor, 0 = application processor |
| ipi_busy | input | 1 | An IPI send or receive is in flight |
| wr_en | input | 1 | Write strobe, one cycle |
| addr | input | AW | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word |
| sw_enabled | output | 1 | Effective software enable |
| msg_valid | input | 1 | Incoming control message present |
| msg_type | input | 3 | Message code |
| msg_accept | output | 1 | Message is to be acted on |
| init_pin | input | 1 | INIT pin |
| init_accept | output | 1 | INIT pin is to be acted on |
| stopclk_pin | input | 1 | Clock-stop pin |
| stopclk_accept | output | 1 | Clock-stop pin is to be acted on |

## Verification
The register file and `sw_enabled` change at the clock edge where `wr_en` is sampled high, and not at any earlier point. The bench drives each write across one full cycle from a falling edge and reads at the next falling edge. The acceptance outputs and `rdata` are combinational, so the bench samples them 1 ns after changing the inputs, with no clock edge in between. For the deferred disable, the bench checks on the edge of the write that nothing has changed, and on the first edge after `ipi_busy` falls that the state has changed.

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int NVEC    = 256,
  parameter int NLVT    = 6,
  parameter int AW      = 7,
  parameter logic [31:0] VERSION = 32'h0001_0014
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    id_strap,
  input  logic          bsp_role,
  input  logic          ipi_busy,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          sw_enabled,
  input  logic          msg_valid,
  input  logic [2:0]    msg_type,
  output logic          msg_accept,
  input  logic          init_pin,
  output logic          init_accept,
  input  logic          stopclk_pin,
  output logic          stopclk_accept
);
  localparam int NWORD = NVEC / 32;
  localparam logic [AW-1:0] A_ID   = AW'(7'h00);
  localparam logic [AW-1:0] A_VER  = AW'(7'h01);
  localparam logic [AW-1:0] A_ARB  = AW'(7'h02);
  localparam logic [AW-1:0] A_TPR  = AW'(7'h03);
  localparam logic [AW-1:0] A_LDR  = AW'(7'h04);
  localparam logic [AW-1:0] A_DFR  = AW'(7'h05);
  localparam logic [AW-1:0] A_SPV  = AW'(7'h06);
  localparam logic [AW-1:0] A_CMDL = AW'(7'h07);
  localparam logic [AW-1:0] A_CMDH = AW'(7'h08);
  localparam logic [AW-1:0] A_TINI = AW'(7'h09);
  localparam logic [AW-1:0] A_TCUR = AW'(7'h0A);
  localparam logic [AW-1:0] A_TDIV = AW'(7'h0B);
  localparam int B_LVT = 'h10;
  localparam int B_REQ = 'h20;
  localparam int B_ISV = 'h28;
  localparam int B_TRG = 'h30;

  localparam logic [2:0] M_INIT = 3'd0, M_NMI = 3'd1, M_SMI = 3'd2,
                         M_START = 3'd3, M_FIXED = 3'd4;

  logic [7:0]      id_q, arb_q, tpr_q;
  logic [31:0]     ldr_q, dfr_q, tini_q, tcur_q;
  logic [63:0]     cmd_q;
  logic [3:0]      tdiv_q;
  logic [8:0]      spv_q;
  logic [NVEC-1:0] req_q, isv_q, trg_q;
  logic [NLVT-1:0] lvt_mask_q;
  logic [15:0]     lvt_fld_q [NLVT];
  logic            en_q, spv_wr;
  logic [8:0]      spv_next;
  logic            en_next;

  assign spv_wr   = wr_en && addr == A_SPV;
  assign spv_next = spv_wr ? wdata[8:0] : spv_q;
  assign en_next  = spv_next[8] | (en_q & ipi_busy);
  assign sw_enabled = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q <= id_strap; arb_q <= id_strap; tpr_q <= '0;
      ldr_q <= '0; dfr_q <= '1; tini_q <= '0; tcur_q <= '0;
      cmd_q <= '0; tdiv_q <= '0; spv_q <= 9'h0FF; en_q <= 1'b0;
      req_q <= '0; isv_q <= '0; trg_q <= '0;
      lvt_mask_q <= '1;
      for (int i = 0; i < NLVT; i++) lvt_fld_q[i] <= '0;
    end else begin
      spv_q <= spv_next;
      en_q  <= en_next;
      if (wr_en) begin
        case (addr)
          A_ID:   id_q   <= wdata[7:0];
          A_TPR:  tpr_q  <= wdata[7:0];
          A_LDR:  ldr_q  <= wdata;
          A_DFR:  dfr_q  <= wdata;
          A_CMDL: cmd_q[31:0]  <= wdata;
          A_CMDH: cmd_q[63:32] <= wdata;
          A_TINI: begin tini_q <= wdata; tcur_q <= wdata; end
          A_TDIV: tdiv_q <= wdata[3:0];
          default: ;
        endcase
        for (int w = 0; w < NWORD; w++) begin
          if (addr == AW'(B_REQ + w)) req_q[w*32 +: 32] <= wdata;
          if (addr == AW'(B_ISV + w)) isv_q[w*32 +: 32] <= wdata;
          if (addr == AW'(B_TRG + w)) trg_q[w*32 +: 32] <= wdata;
        end
      end
      for (int i = 0; i < NLVT; i++) begin
        if (wr_en && addr == AW'(B_LVT + i)) begin
          lvt_fld_q[i]  <= wdata[15:0];
          lvt_mask_q[i] <= wdata[16] | ~en_next;
        end else if (!en_next) begin
          lvt_mask_q[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_ID:   rdata = {24'd0, id_q};
      A_VER:  rdata = VERSION;
      A_ARB:  rdata = {24'd0, arb_q};
      A_TPR:  rdata = {24'd0, tpr_q};
      A_LDR:  rdata = ldr_q;
      A_DFR:  rdata = dfr_q;
      A_SPV:  rdata = {23'd0, spv_q};
      A_CMDL: rdata = cmd_q[31:0];
      A_CMDH: rdata = cmd_q[63:32];
      A_TINI: rdata = tini_q;
      A_TCUR: rdata = tcur_q;
      A_TDIV: rdata = {28'd0, tdiv_q};
      default: ;
    endcase
    for (int i = 0; i < NLVT; i++)
      if (addr == AW'(B_LVT + i)) rdata = {15'd0, lvt_mask_q[i], lvt_fld_q[i]};
    for (int w = 0; w < NWORD; w++) begin
      if (addr == AW'(B_REQ + w)) rdata = req_q[w*32 +: 32];
      if (addr == AW'(B_ISV + w)) rdata = isv_q[w*32 +: 32];
      if (addr == AW'(B_TRG + w)) rdata = trg_q[w*32 +: 32];
    end
  end

  logic type_ok;
  always_comb begin
    case (msg_type)
      M_INIT, M_NMI, M_SMI: type_ok = 1'b1;
      M_START:              type_ok = ~bsp_role;
      M_FIXED:              type_ok = en_q;
      default:              type_ok = 1'b0;
    endcase
  end
  assign msg_accept     = msg_valid & type_ok;
  assign init_accept    = init_pin;
  assign stopclk_accept = stopclk_pin & bsp_role;
endmodule

// File: rtl/intc_regs_chk.sv
module intc_regs_chk #(
  parameter int NVEC = 256,
  parameter int NLVT = 6,
  parameter int AW   = 7,
  parameter logic [31:0] VERSION = 32'h0001_0014
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_enabled,
  input logic          ipi_busy,
  input logic          bsp_role,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   rdata,
  input logic          msg_valid,
  input logic [2:0]    msg_type,
  input logic          msg_accept,
  input logic          stopclk_pin,
  input logic          stopclk_accept,
  input logic [NLVT-1:0] lvt_masks,
  input logic [NVEC-1:0] req_bits,
  input logic [NVEC-1:0] isv_bits
);
  a_r6_masks_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_enabled |-> &lvt_masks);
  a_r8_busy_holds_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sw_enabled && ipi_busy |=> sw_enabled);
  a_r11_masks_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_enabled) |-> &lvt_masks);
  a_r7_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(req_bits) && $stable(isv_bits));
  a_r9_no_startup_bsp: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd3 && bsp_role |-> !msg_accept);
  a_r9_fixed_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd4 && !sw_enabled |-> !msg_accept);
  a_r10_stopclk_app: assert property (@(posedge clk) disable iff (!rst_n)
    !bsp_role |-> !stopclk_accept);
  a_r5_version: assert property (@(posedge clk) disable iff (!rst_n)
    addr == AW'(1) |-> rdata == VERSION);
endmodule

bind intc_regs intc_regs_chk #(.NVEC(NVEC), .NLVT(NLVT), .AW(AW), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_enabled(sw_enabled), .ipi_busy(ipi_busy),
  .bsp_role(bsp_role), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .msg_valid(msg_valid), .msg_type(msg_type), .msg_accept(msg_accept),
  .stopclk_pin(stopclk_pin), .stopclk_accept(stopclk_accept),
  .lvt_masks(lvt_mask_q), .req_bits(req_q), .isv_bits(isv_q));

// File: tb/tb_intc_regs.sv
`timescale 1ns/1ps
module tb_intc_regs;
  localparam int AW = 7;
  localparam logic [31:0] VER = 32'h0001_0014;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] id_strap = 8'h5A;
  logic bsp_role = 1'b1, ipi_busy = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sw_enabled, msg_valid = 1'b0, msg_accept, init_pin = 1'b0, init_accept;
  logic stopclk_pin = 1'b0, stopclk_accept;
  logic [2:0] msg_type = '0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  intc_regs dut (.clk(clk), .rst_n(rst_n), .id_strap(id_strap), .bsp_role(bsp_role),
    .ipi_busy(ipi_busy), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sw_enabled(sw_enabled), .msg_valid(msg_valid), .msg_type(msg_type),
    .msg_accept(msg_accept), .init_pin(init_pin), .init_accept(init_accept),
    .stopclk_pin(stopclk_pin), .stopclk_accept(stopclk_accept));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    addr = a; #1; check(req, rdata, exp);
  endtask

  task automatic t_reset_values;
    rd_chk("R1 tpr", 7'h03, 0); rd_chk("R1 ldr", 7'h04, 0);
    rd_chk("R1 cmd lo", 7'h07, 0); rd_chk("R1 cmd hi", 7'h08, 0);
    rd_chk("R1 timer init", 7'h09, 0); rd_chk("R1 timer cur", 7'h0A, 0);
    rd_chk("R1 divide", 7'h0B, 0);
    for (int w = 0; w < 8; w++) begin
      rd_chk("R1 request", 7'(8'h20 + w), 0);
      rd_chk("R1 in-service", 7'(8'h28 + w), 0);
      rd_chk("R1 trigger", 7'(8'h30 + w), 0);
    end
    rd_chk("R2 dest format", 7'h05, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) rd_chk("R3 vector entry", 7'(8'h10 + i), 32'h0001_0000);
    rd_chk("R4 spurious", 7'h06, 32'h0FF);
    check("R4 sw_enabled", {31'd0, sw_enabled}, 0);
    rd_chk("R5 id", 7'h00, 32'h5A); rd_chk("R5 arb id", 7'h02, 32'h5A);
    rd_chk("R5 version", 7'h01, VER);
  endtask

  task automatic t_enable_and_write;
    wr(7'h06, 32'h1AB);
    check("R12 sw_enabled after enable", {31'd0, sw_enabled}, 1);
    rd_chk("R12 spurious", 7'h06, 32'h1AB);
    rd_chk("R11 mask still set", 7'h10, 32'h0001_0000);
    wr(7'h10, 32'h0000_0020);
    rd_chk("R11 mask cleared by write", 7'h10, 32'h0000_0020);
    wr(7'h11, 32'h0001_0033);
    rd_chk("R12 entry write", 7'h11, 32'h0001_0033);
    wr(7'h20, 32'hA5A5_0001);
    wr(7'h29, 32'h8000_0000);
    wr(7'h09, 32'h0000_1234);
    rd_chk("R12 timer init", 7'h09, 32'h1234);
    rd_chk("R12 timer cur loaded", 7'h0A, 32'h1234);
    wr(7'h0B, 32'hFB);
    rd_chk("R12 divide", 7'h0B, 32'hB);
    wr(7'h00, 32'h77);
    rd_chk("R12 id write", 7'h00, 32'h77);
    rd_chk("R5 arb id unchanged", 7'h02, 32'h5A);
  endtask

  task automatic t_disable;
    wr(7'h06, 32'h0FF);
    check("R8 disable immediate", {31'd0, sw_enabled}, 0);
    rd_chk("R6 mask forced", 7'h10, 32'h0001_0020);
    wr(7'h10, 32'h0000_0044);
    rd_chk("R6 clear ignored", 7'h10, 32'h0001_0044);
    rd_chk("R7 request held", 7'h20, 32'hA5A5_0001);
    rd_chk("R7 in-service held", 7'h29, 32'h8000_0000);
  endtask

  task automatic t_reenable;
    wr(7'h06, 32'h1FF);
    check("R11 enabled", {31'd0, sw_enabled}, 1);
    rd_chk("R11 mask stays", 7'h10, 32'h0001_0044);
    rd_chk("R11 other mask stays", 7'h11, 32'h0001_0033);
    wr(7'h10, 32'h0000_0044);
    rd_chk("R11 mask cleared", 7'h10, 32'h0000_0044);
    rd_chk("R7 request after reenable", 7'h20, 32'hA5A5_0001);
  endtask

  task automatic t_ipi_defer;
    @(negedge clk); ipi_busy = 1'b1;
    wr(7'h06, 32'h0FF);
    check("R8 held while busy", {31'd0, sw_enabled}, 1);
    rd_chk("R8 mask untouched while busy", 7'h10, 32'h0000_0044);
    @(negedge clk);
    check("R8 still held", {31'd0, sw_enabled}, 1);
    ipi_busy = 1'b0;
    @(negedge clk);
    check("R8 drops after busy", {31'd0, sw_enabled}, 0);
    rd_chk("R8 mask forced after busy", 7'h10, 32'h0001_0044);
  endtask

  task automatic t_messages;
    for (int en = 0; en < 2; en++) begin
      wr(7'h06, en ? 32'h1FF : 32'h0FF);
      for (int r = 0; r < 2; r++) begin
        for (int t = 0; t < 8; t++) begin
          logic exp;
          bsp_role = r[0]; msg_type = t[2:0]; msg_valid = 1'b1; #1;
          exp = (t <= 2) || (t == 3 && r == 0) || (t == 4 && en == 1);
          check("R9 accept", {31'd0, msg_accept}, {31'd0, exp});
          msg_valid = 1'b0; #1;
          check("R9 no valid", {31'd0, msg_accept}, 0);
        end
      end
    end
  endtask

  task automatic t_pins;
    for (int r = 0; r < 2; r++) begin
      bsp_role = r[0]; init_pin = 1'b1; stopclk_pin = 1'b1; #1;
      check("R10 init pin", {31'd0, init_accept}, 1);
      check("R10 stopclk pin", {31'd0, stopclk_accept}, {31'd0, r[0]});
      init_pin = 1'b0; stopclk_pin = 1'b0; #1;
      check("R10 init idle", {31'd0, init_accept}, 0);
      check("R10 stopclk idle", {31'd0, stopclk_accept}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_values;
    t_enable_and_write;
    t_disable;
    t_reenable;
    t_ipi_defer;
    t_messages;
    t_pins;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule